// File: doc/BRIEF.md
# SD Card Command Issuer

This block issues one SD card command at a time on the single-bit CMD line and collects the card's reply. Software programs it through a small register port. One register sets the SD clock as an integer ratio of the system clock. Another holds the 32-bit command argument. A third takes the command index, and writing it starts the transaction. The outcome is read back from a status word and up to four response words.

After a launch, the block frames a 48-bit command with a CRC7 trailer and shifts it out MSB first. Output bits change only on falling SD clock edges. The block then releases the line and waits a bounded number of SD clock periods for a response start bit. It shifts in a short (48-bit) or long (136-bit) reply, depending on the index, and posts a completion code. Index 0 completes as soon as its stop bit has been sent.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset the status word reads 0 (busy 0, code 0), cmd_oe is 0, cmd_out is 1, sd_clk is 0, and the SD clock period is DEF_RATIO (4) system cycles.
- R2: A write to address 0 loads the clock ratio from wr_data[7:0], and sd_clk then has a period of that many system cycles. A value below 2 leaves the ratio unchanged.
- R3: The command frame is 48 bits, sent MSB first. It consists of bit 0, bit 1, the 6-bit index, the 32-bit argument, a CRC7 and a stop bit of 1. The CRC7 is taken over the first 40 bits with polynomial x^7+x^3+1 from a zero start. For index 0 with argument 0, the last frame byte is 0x95.
- R4: cmd_oe is high for exactly the 48 frame bits. cmd_out and cmd_oe change only on system edges where sd_clk falls. The line is released on the first falling sd_clk after the stop bit.
- R5: The argument written at address 1 is captured at launch. Argument writes made while a command is in flight do not alter its frame.
- R6: A write to address 2 launches only for the values 0, 2, 3, 7, 12 and 41. Any other value, including values of 64 or more, sets completion code 3 with busy 0 and no activity on cmd_oe.
- R7: Index 0 completes with code 1 without waiting for a response. Index 2 receives a 136-bit response and all other supported indices receive a 48-bit response. In both cases the command ends with code 1.
- R8: A start bit (cmd_in 0 at a rising sd_clk) is accepted up to the 64th rising edge after the line is released. If 64 consecutive samples read 1, the command ends with code 2.
- R9: Status bit 31 (busy) reads 1 from the cycle after the launch write until completion. Index writes and ratio writes made while busy are ignored.
- R10: Read address 0 returns {busy, 29 zeros, code[1:0]}. Addresses 1 to 4 return received bits [39:8], [71:40], [103:72] and [135:104]. The last received bit sits at position 0, and the response is cleared at launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 ratio, 1 argument, 2 index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address: 0 status, 1..4 response words |
| rd_data | output | 32 | Read data (combinational) |
| sd_clk | output | 1 | Divided SD clock |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line sampled value |

## Verification
The bench builds the block with its default parameters: an 8-bit ratio field, a reset ratio of 4, a 64-period response window and a 136-bit response register. These values let the bench sweep ratios 2 to 7, including the odd ratios where the high and low phases differ. They also let it place the response start bit exactly on the 64th sample and one sample past it. A full long response is small enough to compare word by word after every random command.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  localparam int FRAME_W = 48;
  localparam int LEN_W   = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RECV} eng_state_t;

  localparam logic [1:0] CODE_NONE = 2'd0;
  localparam logic [1:0] CODE_OK   = 2'd1;
  localparam logic [1:0] CODE_TOUT = 2'd2;
  localparam logic [1:0] CODE_BAD  = 2'd3;

  // serial CRC7, generator x^7 + x^3 + 1, zero start, MSB first
  function automatic logic [6:0] crc7_of(input logic [39:0] bits);
    logic [6:0] c;
    logic fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [5:0] idx,
                                                     input logic [31:0] arg);
    logic [39:0] head;
    head = {2'b01, idx, arg};
    return {head, crc7_of(head), 1'b1};
  endfunction

  function automatic logic idx_supported(input logic [5:0] idx);
    case (idx)
      6'd0, 6'd2, 6'd3, 6'd7, 6'd12, 6'd41: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction

  // response length in bits, 0 = no response
  function automatic logic [LEN_W-1:0] resp_len(input logic [5:0] idx);
    case (idx)
      6'd0:    return LEN_W'(0);
      6'd2:    return LEN_W'(136);
      default: return LEN_W'(48);
    endcase
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
`timescale 1ns/1ps
module sdcmd_clkgen #(
  parameter int RATIO_W   = 8,
  parameter int DEF_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sd_clk,
  output logic               rise_evt,
  output logic               fall_evt
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half;

  assign half     = ratio >> 1;
  assign sd_clk   = (cnt >= half);
  assign rise_evt = (cnt == half - RATIO_W'(1));  // sd_clk rises at this edge
  assign fall_evt = (cnt >= ratio - RATIO_W'(1)); // sd_clk falls at this edge

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (fall_evt) cnt <= '0;
    else               cnt <= cnt + RATIO_W'(1);
  end

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt)); // R2
  AST_FALL_DROPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !sd_clk); // R2
endmodule

// File: rtl/sdcmd_engine.sv
`timescale 1ns/1ps
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int RESP_W  = 136
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              start,
  input  logic [5:0]        start_idx,
  input  logic [31:0]       start_arg,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic [1:0]        code,
  output logic [RESP_W-1:0] resp
);
  localparam int WCNT_W = $clog2(TIMEOUT + 1);
  localparam int BCNT_W = $clog2(FRAME_W + 1);

  eng_state_t          st;
  logic [FRAME_W-1:0]  sh;
  logic [BCNT_W-1:0]   bcnt;
  logic [WCNT_W-1:0]   wcnt;
  logic [LEN_W-1:0]    rcnt;
  logic [LEN_W-1:0]    rlen;
  logic [5:0]          cur_idx;

  // named events for the checks below
  logic launch_ok, launch_bad, send_done, got_start, wait_expire, recv_last;

  assign busy        = (st != ST_IDLE);
  assign rlen        = resp_len(cur_idx);
  assign launch_ok   = start && !busy && idx_supported(start_idx);
  assign launch_bad  = start && !busy && !idx_supported(start_idx);
  assign send_done   = (st == ST_SEND) && fall_evt && (bcnt == BCNT_W'(FRAME_W));
  assign got_start   = (st == ST_WAIT) && rise_evt && !cmd_in;
  assign wait_expire = (st == ST_WAIT) && rise_evt && cmd_in &&
                       (wcnt == WCNT_W'(TIMEOUT - 1));
  assign recv_last   = (st == ST_RECV) && rise_evt && (rcnt == rlen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      bcnt    <= '0;
      wcnt    <= '0;
      rcnt    <= '0;
      cur_idx <= '0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      code    <= CODE_NONE;
      resp    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (launch_ok) begin
            sh      <= build_frame(start_idx, start_arg);
            bcnt    <= '0;
            cur_idx <= start_idx;
            resp    <= '0;
            code    <= CODE_NONE;
            st      <= ST_SEND;
          end else if (launch_bad) begin
            code <= CODE_BAD;
          end
        end
        ST_SEND: begin
          if (fall_evt) begin
            if (!send_done) begin
              cmd_out <= sh[FRAME_W-1];
              cmd_oe  <= 1'b1;
              sh      <= sh << 1;
              bcnt    <= bcnt + BCNT_W'(1);
            end else begin
              cmd_out <= 1'b1;
              cmd_oe  <= 1'b0;
              wcnt    <= '0;
              rcnt    <= '0;
              if (rlen == LEN_W'(0)) begin
                code <= CODE_OK;
                st   <= ST_IDLE;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
        end
        ST_WAIT: begin
          if (got_start) begin
            resp <= {resp[RESP_W-2:0], 1'b0};
            rcnt <= LEN_W'(1);
            st   <= ST_RECV;
          end else if (wait_expire) begin
            code <= CODE_TOUT;
            st   <= ST_IDLE;
          end else if (rise_evt) begin
            wcnt <= wcnt + WCNT_W'(1);
          end
        end
        ST_RECV: begin
          if (rise_evt) begin
            resp <= {resp[RESP_W-2:0], cmd_in};
            rcnt <= rcnt + LEN_W'(1);
            if (recv_last) begin
              code <= CODE_OK;
              st   <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy); // R4
  AST_LINE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> ($stable(cmd_out) && $stable(cmd_oe))); // R4
  AST_BAD_INDEX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_bad |=> (!busy && code == CODE_BAD && !cmd_oe)); // R6
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expire |=> (!busy && code == CODE_TOUT)); // R8
  AST_BUSY_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cur_idx)); // R9
  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ok |=> busy); // R9
endmodule

// File: rtl/sdcmd_issuer.sv
`timescale 1ns/1ps
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int RATIO_W   = 8,
  parameter int DEF_RATIO = 4,
  parameter int TIMEOUT   = 64,
  parameter int RESP_W    = 136
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sd_clk,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  localparam int NWORDS = 4;

  logic [RATIO_W-1:0] ratio;
  logic [31:0]        arg_q;
  logic               rise_evt, fall_evt, busy, start, ratio_we;
  logic [5:0]         start_idx;
  logic [1:0]         code;
  logic [RESP_W-1:0]  resp;
  logic [31:0]        words [NWORDS];

  assign ratio_we  = wr_en && (wr_addr == 2'd0) && !busy &&
                     (wr_data[RATIO_W-1:0] >= RATIO_W'(2));
  assign start     = wr_en && (wr_addr == 2'd2);
  // values that do not fit the 6-bit field map to an unsupported index
  assign start_idx = (wr_data[31:6] == '0) ? wr_data[5:0] : 6'd63;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio <= RATIO_W'(DEF_RATIO);
      arg_q <= '0;
    end else begin
      if (ratio_we) ratio <= wr_data[RATIO_W-1:0];
      if (wr_en && wr_addr == 2'd1) arg_q <= wr_data;
    end
  end

  sdcmd_clkgen #(.RATIO_W(RATIO_W), .DEF_RATIO(DEF_RATIO)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .ratio(ratio),
    .sd_clk(sd_clk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  sdcmd_engine #(.TIMEOUT(TIMEOUT), .RESP_W(RESP_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .start(start), .start_idx(start_idx), .start_arg(arg_q),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .busy(busy), .code(code), .resp(resp)
  );

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign words[k] = resp[8 + 32*k +: 32];
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {busy, 29'd0, code};
      3'd1:    rd_data = words[0];
      3'd2:    rd_data = words[1];
      3'd3:    rd_data = words[2];
      3'd4:    rd_data = words[3];
      default: rd_data = '0;
    endcase
  end

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[RATIO_W-1:0] < RATIO_W'(2)) |=> $stable(ratio)); // R2
  AST_RATIO_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 2'd0) |=> $stable(ratio)); // R9
endmodule

// File: tb/sdcmd_issuer_bench.sv
`timescale 1ns/1ps
module sdcmd_issuer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sd_clk, cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int sup [6] = '{0, 2, 3, 7, 12, 41};

  always #10 clk = ~clk; // 50 MHz

  sdcmd_issuer u_sdcmd_issuer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // frame by long division with 0x89 (x^7+x^3+1)
  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [46:0] w;
    w = {2'b01, idx, arg, 7'd0};
    for (int i = 46; i >= 7; i--)
      if (w[i]) w[i -: 8] = w[i -: 8] ^ 8'h89;
    return {2'b01, idx, arg, w[6:0], 1'b1};
  endfunction

  function automatic int exp_len(input logic [5:0] idx);
    if (idx == 6'd0) return 0;
    if (idx == 6'd2) return 136;
    return 48;
  endfunction

  function automatic logic [135:0] mk_resp(input int len);
    logic [135:0] v;
    for (int i = 0; i < 136; i++) v[i] = 1'($urandom % 2);
    for (int i = len; i < 136; i++) v[i] = 1'b0;
    if (len > 0) begin
      v[len-1] = 1'b0;
      v[0]     = 1'b1;
    end
    return v;
  endfunction

  task automatic measure(input int exp_ratio, input string tag);
    time t0;
    @(posedge sd_clk);
    @(posedge sd_clk);
    t0 = $time;
    @(posedge sd_clk);
    chk(tag, 64'(($time - t0) / 20), 64'(exp_ratio));
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input int delay,
                         input logic [135:0] respv, input bit meddle);
    logic [47:0] fr;
    logic [31:0] st;
    int got, len;
    len = exp_len(idx);
    wr(2'd1, arg);
    wr(2'd2, {26'd0, idx});
    rd(3'd0, st);
    chk("R9 busy after launch", 64'(st[31]), 64'd1);
    got = 0; fr = '0;
    fork
      begin
        while (got < 48) begin
          @(posedge sd_clk); #1;
          if (cmd_oe) begin fr = {fr[46:0], cmd_out}; got++; end
        end
      end
      begin
        if (meddle) begin
          wr(2'd2, 32'd3);
          wr(2'd1, ~arg);
          wr(2'd0, 32'd6);
        end
      end
    join
    if (meddle) chk("R5 frame keeps launch argument", 64'(fr), 64'(exp_frame(idx, arg)));
    else        chk("R3 frame", 64'(fr), 64'(exp_frame(idx, arg)));
    @(negedge sd_clk); #1;
    chk("R4 line released after stop bit", 64'(cmd_oe), 64'd0);
    if (len > 0 && delay <= 64) begin
      if (delay > 1) repeat (delay - 1) @(negedge sd_clk);
      for (int i = len - 1; i >= 0; i--) begin
        cmd_in = respv[i];
        @(negedge sd_clk);
      end
      cmd_in = 1'b1;
    end
    do rd(3'd0, st); while (st[31]);
    if (len == 0)        chk("R7 no-response completion", 64'(st), 64'd1);
    else if (delay > 64) chk("R8 timeout code", 64'(st), 64'd2);
    else begin
      chk("R7 response completion", 64'(st), 64'd1);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] d;
        rd(3'(k + 1), d);
        chk("R10 response word", 64'(d), 64'(respv[8 + 32*k +: 32]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] st;
    logic [47:0] fr0;
    int seen, ratio_now, seed;
    seed = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 sd_clk low in reset", 64'(sd_clk), 64'd0);
    rst_n = 1'b1;
    rd(3'd0, st);
    chk("R1 status after reset", 64'(st), 64'd0);
    chk("R1 cmd_oe after reset", 64'(cmd_oe), 64'd0);
    chk("R1 cmd_out after reset", 64'(cmd_out), 64'd1);
    measure(4, "R1 default period");

    wr(2'd0, 32'd1);
    measure(4, "R2 ratio 1 ignored");
    wr(2'd0, 32'd0);
    measure(4, "R2 ratio 0 ignored");
    wr(2'd0, 32'd2);
    measure(2, "R2 ratio 2");

    fr0 = exp_frame(6'd0, 32'd0);
    chk("R3 CRC of index 0 frame", 64'(fr0[7:0]), 64'h95);
    run_cmd(6'd0, 32'd0, 1, '0, 1'b0);

    wr(2'd0, 32'd3);
    measure(3, "R2 ratio 3");
    run_cmd(6'd2, 32'h1234_5678, 1, mk_resp(136), 1'b0);
    run_cmd(6'd3, 32'hFFFF_0000, 64, mk_resp(48), 1'b0);
    run_cmd(6'd7, 32'hA5A5_0001, 65, mk_resp(48), 1'b0);

    wr(2'd2, 32'd5);
    rd(3'd0, st);
    chk("R6 index 5 rejected", 64'(st), 64'd3);
    wr(2'd2, 32'd66);
    rd(3'd0, st);
    chk("R6 index 66 rejected", 64'(st), 64'd3);
    seen = 0;
    repeat (40) begin @(negedge clk); if (cmd_oe) seen++; end
    chk("R6 no line activity", 64'(seen), 64'd0);

    run_cmd(6'd7, 32'hCAFE_F00D, 5, mk_resp(48), 1'b1);
    seen = 0;
    repeat (60) begin @(negedge clk); if (cmd_oe) seen++; end
    rd(3'd0, st);
    chk("R9 index write while busy dropped", 64'(st), 64'd1);
    chk("R9 no second frame", 64'(seen), 64'd0);
    measure(3, "R9 ratio write while busy dropped");

    for (int n = 0; n < 36; n++) begin
      logic [5:0] idx;
      int dly;
      ratio_now = 2 + int'($urandom % 6);
      wr(2'd0, 32'(ratio_now));
      if (n % 6 == 0) measure(ratio_now, "R2 random ratio");
      idx = 6'(sup[$urandom % 6]);
      dly = ($urandom % 10 == 0) ? 65 + int'($urandom % 4) : 1 + int'($urandom % 64);
      run_cmd(idx, $urandom, dly, mk_resp(exp_len(idx)), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule